// File: doc/BRIEF.md
# Generalized Cube XOR-Tag Router

This block is an eight-port, three-stage multistage switch built from 2x2 straight/exchange elements. Each element joins two links whose labels differ in one bit position. The first stage resolves the most significant label bit, the middle stage the next bit, and the last stage the least significant bit. A packet enters on the port whose index is its source label and carries a destination label. The router computes the routing tag as source XOR destination. Each stage reads its own tag bit: 0 sets the element straight and 1 sets it to exchange. After the last stage the packet leaves on the output port equal to its destination.

The switch is unbuffered. When the two packets at one element need opposite settings, they compete for the same outgoing link. The element keeps the packet on its upper input (the link with that bit clear), drops the other one, and flags the loser's source port as blocked. In partition mode the network is split into an upper half (ports 0..3) and a lower half (ports 4..7). A packet whose source and destination lie in different halves is refused at the input and reported. Refused packets never enter the stages, so neither half can disturb the other. Every result is registered, so it appears one clock after the inputs are sampled.

Top module: `gcube_xor_router`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, out_data, blocked and part_viol are all zero.
- R2: A packet sampled at a rising edge with in_valid[i] set appears at its output port after that same edge: out_valid and out_data are updated by that edge and stay until the next one.
- R3: The tag is source XOR destination. The stage for bit b (bit 2, then 1, then 0) goes straight for tag bit 0 and exchanges for tag bit 1. A lone packet from port i with destination d (3-bit field i of in_dest) leaves on out port d with its payload; for example 1 to 3 uses tag 2.
- R4: Any permutation of the form destination = source XOR k, for a constant k, with all eight inputs valid, is delivered completely with no blocked port.
- R5: When two valid packets at one element need opposite settings, the packet on the element's lower-numbered link continues. The other packet is dropped, and blocked at its source port is raised for one cycle.
- R6: Every valid input produces exactly one of three results one cycle later: delivered on an output, blocked, or refused by partition mode.
- R7: With part_en set, a valid packet whose source and destination differ in bit 2 is refused. part_viol is raised at its source port, and the packet neither reaches an output nor blocks another packet.
- R8: With part_en set, the outputs of one half depend only on the inputs of that half.
- R9: An input with in_valid low has no effect. Its destination and payload cause no conflict and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| part_en | input | 1 | Partition mode: refuse traffic that crosses halves |
| in_valid | input | 8 | Per-port packet present |
| in_dest | input | 24 | Per-port destination label, 3 bits per port |
| in_data | input | 64 | Per-port payload, 8 bits per port |
| out_valid | output | 8 | Per-output-port packet delivered |
| out_data | output | 64 | Per-output-port payload |
| blocked | output | 8 | Per-source-port: packet lost a conflict |
| part_viol | output | 8 | Per-source-port: packet refused by partition mode |

## Verification
The checker assumes that each output cycle corresponds to the inputs sampled at the edge before it. For that reason it stays idle until one full cycle after reset has passed. The conservation, refusal and half-isolation properties assume that in_valid and part_en hold steady across the sampling edge. The bench satisfies this by driving all inputs on the falling edge and reading results on the next falling edge. Stimulus mixes directed permutations, pile-ups on one destination, and idle ports carrying garbage destinations, then runs a long random phase with partition mode toggled.

// File: rtl/gcube_xor_router.sv
module gcube_xor_router #(
  parameter int LOG_N = 3,
  parameter int DW    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 part_en,
  input  logic [(1<<LOG_N)-1:0]       in_valid,
  input  logic [(1<<LOG_N)*LOG_N-1:0] in_dest,
  input  logic [(1<<LOG_N)*DW-1:0]    in_data,
  output logic [(1<<LOG_N)-1:0]       out_valid,
  output logic [(1<<LOG_N)*DW-1:0]    out_data,
  output logic [(1<<LOG_N)-1:0]       blocked,
  output logic [(1<<LOG_N)-1:0]       part_viol
);
  localparam int N = 1 << LOG_N;

  logic [N-1:0]       sv [LOG_N+1];
  logic [LOG_N-1:0]   st [LOG_N+1][N];
  logic [LOG_N-1:0]   ss [LOG_N+1][N];
  logic [DW-1:0]      sd [LOG_N+1][N];
  logic [N-1:0]       blk_c, pv_c;

  always_comb begin
    logic [LOG_N-1:0] sl, dl;
    logic cf, xch, lv;
    int hi, lo, b;
    blk_c = '0;
    pv_c  = '0;
    for (int s = 0; s <= LOG_N; s++)
      for (int j = 0; j < N; j++) begin
        sv[s][j] = 1'b0;
        st[s][j] = '0;
        ss[s][j] = '0;
        sd[s][j] = '0;
      end
    for (int i = 0; i < N; i++) begin
      sl = LOG_N'(i);
      dl = in_dest[i*LOG_N +: LOG_N];
      pv_c[i]  = in_valid[i] && part_en && (sl[LOG_N-1] != dl[LOG_N-1]);
      sv[0][i] = in_valid[i] && !pv_c[i];
      st[0][i] = sl ^ dl;
      ss[0][i] = sl;
      sd[0][i] = in_data[i*DW +: DW];
    end
    for (int s = 0; s < LOG_N; s++) begin
      b = LOG_N - 1 - s;
      for (int j = 0; j < N; j++) begin
        if (((j >> b) & 1) == 0) begin
          hi  = j;
          lo  = j + (1 << b);
          cf  = sv[s][hi] && sv[s][lo] && (st[s][hi][b] != st[s][lo][b]);
          if (cf) blk_c[ss[s][lo]] = 1'b1;
          lv  = sv[s][lo] && !cf;
          xch = sv[s][hi] ? st[s][hi][b] : st[s][lo][b];
          if (xch) begin
            sv[s+1][lo] = sv[s][hi];
            st[s+1][lo] = st[s][hi];
            ss[s+1][lo] = ss[s][hi];
            sd[s+1][lo] = sd[s][hi];
            sv[s+1][hi] = lv;
            st[s+1][hi] = st[s][lo];
            ss[s+1][hi] = ss[s][lo];
            sd[s+1][hi] = sd[s][lo];
          end else begin
            sv[s+1][hi] = sv[s][hi];
            st[s+1][hi] = st[s][hi];
            ss[s+1][hi] = ss[s][hi];
            sd[s+1][hi] = sd[s][hi];
            sv[s+1][lo] = lv;
            st[s+1][lo] = st[s][lo];
            ss[s+1][lo] = ss[s][lo];
            sd[s+1][lo] = sd[s][lo];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_data  <= '0;
      blocked   <= '0;
      part_viol <= '0;
    end else begin
      out_valid <= sv[LOG_N];
      blocked   <= blk_c;
      part_viol <= pv_c;
      for (int j = 0; j < N; j++) out_data[j*DW +: DW] <= sd[LOG_N][j];
    end
  end
endmodule

// File: rtl/gcube_xor_router_chk.sv
module gcube_xor_router_chk #(
  parameter int LOG_N = 3,
  parameter int DW    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 part_en,
  input logic [(1<<LOG_N)-1:0] in_valid,
  input logic [(1<<LOG_N)-1:0] out_valid,
  input logic [(1<<LOG_N)-1:0] blocked,
  input logic [(1<<LOG_N)-1:0] part_viol
);
  localparam int N = 1 << LOG_N;
  localparam int H = N / 2;

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R6
  conserve_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($countones(out_valid) + $countones(blocked) + $countones(part_viol)) == $past($countones(in_valid)));

  // R5
  blk_src_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ((blocked & ~$past(in_valid)) == '0) && ((blocked & part_viol) == '0));

  // R7
  viol_mode_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(part_en) |-> (part_viol == '0));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(in_valid) == '0) |-> (out_valid == '0 && blocked == '0 && part_viol == '0));

  // R8
  half_iso_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(part_en) |-> ($countones(out_valid[H-1:0]) <= $past($countones(in_valid[H-1:0]))));
endmodule

bind gcube_xor_router gcube_xor_router_chk #(.LOG_N(LOG_N), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .part_en(part_en), .in_valid(in_valid),
  .out_valid(out_valid), .blocked(blocked), .part_viol(part_viol)
);

// File: tb/tb_gcube_xor_router.sv
`timescale 1ns/1ps
module tb_gcube_xor_router;
  localparam int LOG_N = 3;
  localparam int DW    = 8;
  localparam int N     = 1 << LOG_N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic part_en = 1'b0;
  logic [N-1:0]       in_valid = '0;
  logic [N*LOG_N-1:0] in_dest  = '0;
  logic [N*DW-1:0]    in_data  = '0;
  logic [N-1:0]       out_valid, blocked, part_viol;
  logic [N*DW-1:0]    out_data;

  gcube_xor_router #(.LOG_N(LOG_N), .DW(DW)) dut (
    .clk(clk), .rst(rst), .part_en(part_en), .in_valid(in_valid),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .blocked(blocked), .part_viol(part_viol)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  int tv[N], td[N], tdat[N];
  bit tpen;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int pos[N]; bit alive[N], lose[N];
    int ev, eb, ep; int ed[N];
    ev = 0; eb = 0; ep = 0;
    for (int i = 0; i < N; i++) begin
      in_valid[i] = tv[i][0];
      in_dest[i*LOG_N +: LOG_N] = LOG_N'(td[i]);
      in_data[i*DW +: DW] = DW'(tdat[i]);
      ed[i] = 0;
    end
    part_en = tpen;
    for (int i = 0; i < N; i++) begin
      alive[i] = tv[i] != 0;
      pos[i] = i;
      if (alive[i] && tpen && (((i ^ td[i]) >> (LOG_N-1)) & 1) == 1) begin
        ep |= 1 << i; alive[i] = 0;
      end
    end
    for (int s = 0; s < LOG_N; s++) begin
      int b; b = LOG_N - 1 - s;
      for (int i = 0; i < N; i++) lose[i] = 0;
      for (int i = 0; i < N; i++)
        for (int k = 0; k < N; k++)
          if (i != k && alive[i] && alive[k] && ((pos[i] ^ pos[k]) == (1 << b))
              && (((td[i] >> b) & 1) == ((td[k] >> b) & 1)) && ((pos[i] >> b) & 1) == 1)
            lose[i] = 1;
      for (int i = 0; i < N; i++) begin
        if (lose[i]) begin alive[i] = 0; eb |= 1 << i; end
        pos[i] = (pos[i] & ~(1 << b)) | (td[i] & (1 << b));
      end
    end
    for (int i = 0; i < N; i++)
      if (alive[i]) begin ev |= 1 << pos[i]; ed[pos[i]] = tdat[i] & 8'hff; end
    @(negedge clk);
    check(int'(out_valid) == ev, tag, "out_valid", int'(out_valid), ev);
    check(int'(blocked) == eb, tag, "blocked", int'(blocked), eb);
    check(int'(part_viol) == ep, tag, "part_viol", int'(part_viol), ep);
    for (int j = 0; j < N; j++)
      if ((ev >> j) & 1)
        check(int'(out_data[j*DW +: DW]) == ed[j], tag, "out_data", int'(out_data[j*DW +: DW]), ed[j]);
  endtask

  task automatic clear();
    for (int i = 0; i < N; i++) begin tv[i] = 0; td[i] = 0; tdat[i] = 0; end
    tpen = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == '0 && blocked == '0 && part_viol == '0 && out_data == '0,
          "R1", "reset outputs", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == '0 && out_data == '0, "R1", "after reset", int'(out_valid), 0);

    // R2 R3 lone packet 1 -> 3
    clear(); tv[1] = 1; td[1] = 3; tdat[1] = 8'hA5; step("R2");
    check(out_valid == 8'b0000_1000, "R3", "1to3 port", int'(out_valid), 8);
    for (int i = 0; i < N; i++) begin
      clear(); tv[i] = 1; td[i] = (i * 5 + 3) % N; tdat[i] = 16 + i; step("R3");
    end

    // R4 XOR-constant permutations
    for (int k = 0; k < N; k++) begin
      clear();
      for (int i = 0; i < N; i++) begin tv[i] = 1; td[i] = i ^ k; tdat[i] = k*16 + i; end
      step("R4");
      check(blocked == '0 && out_valid == '1, "R4", "full delivery", int'(out_valid), 255);
    end

    // R5 conflict: 0 -> 0 and 4 -> 2, port 0 wins
    clear(); tv[0] = 1; td[0] = 0; tv[4] = 1; td[4] = 2; tdat[0] = 8'h11; tdat[4] = 8'h44;
    step("R5");
    check(blocked == 8'b0001_0000, "R5", "loser port", int'(blocked), 16);
    // R5 pile-up on one destination
    clear(); for (int i = 0; i < N; i++) begin tv[i] = 1; td[i] = 5; tdat[i] = i; end
    step("R5");
    check($countones(out_valid) == 1, "R6", "one survivor", $countones(out_valid), 1);

    // R9 invalid inputs with garbage
    clear(); for (int i = 0; i < N; i++) begin td[i] = 7 - i; tdat[i] = 99; end
    step("R9");
    clear(); tv[0] = 1; td[0] = 0; td[4] = 2; tdat[4] = 8'h77; step("R9");

    // R7 partition refusal
    clear(); tpen = 1; tv[2] = 1; td[2] = 6; tv[5] = 1; td[5] = 1; tv[3] = 1; td[3] = 0;
    step("R7");
    check(part_viol == 8'b0010_0100, "R7", "refused ports", int'(part_viol), 36);
    // R8 upper-half traffic unaffected by lower-half crossers
    clear(); tpen = 1;
    for (int i = 0; i < N/2; i++) begin tv[i] = 1; td[i] = i ^ 1; tdat[i] = 40 + i; end
    for (int i = N/2; i < N; i++) begin tv[i] = 1; td[i] = i - N/2; tdat[i] = 60 + i; end
    step("R8");
    check(out_valid == 8'b0000_1111, "R8", "halves isolated", int'(out_valid), 15);

    // R6 random traffic
    for (int c = 0; c < 400; c++) begin
      clear();
      tpen = ($urandom % 4) == 0;
      for (int i = 0; i < N; i++) begin
        tv[i] = ($urandom % 3) != 0; td[i] = $urandom % N; tdat[i] = $urandom % 256;
      end
      step("R6");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule